// File: doc/BRIEF.md
# Configuration Access Indirection Bridge

This block is a small register front end that gives a host indirect access to PCI-style configuration space. Software first writes a packed configuration address (enable flag, bus, device, function and dword register number) into an address register. Each later access to the data register then becomes exactly one configuration read or write on a simple downstream request/response interface. The host access is stalled until the downstream completion arrives.

Byte and halfword accesses to the data register are supported. The two low bits of the host offset choose the byte lane. Reads return the selected bytes right-aligned. Writes carry per-byte enables, so the target updates only the selected bytes. Accesses aimed at the secondary bus are refused locally while the downstream link is not ready. Accesses with the enable flag clear are also kept local, as are downstream reads that complete with an error. Such reads return all ones.

Both host channels and the downstream request use valid/ready. A request is taken only on a cycle where valid and ready are both high. `host_req_ready` is high only while the bridge is idle, so at most one transaction is in flight. Once `host_rsp_valid` rises, the response stays valid and unchanged until `host_rsp_ready` is seen. `ds_req_valid` and all request fields stay unchanged until `ds_req_ready` is seen. The downstream response has no ready. The target must raise `ds_rsp_valid` for one cycle, no earlier than the cycle after the request is accepted.

Top module: `cfg_bridge`

## Requirements
- R1: After reset, `host_req_ready` is 1, `host_rsp_valid` and `ds_req_valid` are 0, and the address register reads 0.
- R2: A write to offset 0x20 stores the host data as the packed address. A read of 0x20 returns that value with bits 1:0 forced to 0.
- R3: A downstream request carries the packed address with bits 1:0 zero. The fields are: enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8 and register dword in bits 7:2.
- R4: A read of offset 0x24 issues exactly one downstream read (`ds_req_write`=0). A write issues exactly one downstream write (`ds_req_write`=1).
- R5: Host size encoding is 0 for byte, 1 for halfword and 2 or 3 for word. A byte or halfword read returns the dword shifted right by 8 times offset bits 1:0, masked to 8 or 16 bits. A word read ignores offset bits 1:0.
- R6: A byte write sets one byte enable, at the lane given by offset bits 1:0. A halfword write sets two enables starting at that lane. Host data is shifted up to the lane, and bytes outside the enables are left unchanged at the target.
- R7: When address bit 31 is clear, a data access sends no downstream request. Reads return 0xFFFFFFFF.
- R8: While `link_ready` is 0, a data access whose bus field equals SEC_BUS (default 1) sends no downstream request. It responds with `host_rsp_nf`=1 and read data 0xFFFFFFFF.
- R9: A downstream read that completes with `ds_rsp_err`=1 returns 0xFFFFFFFF to the host, whatever the access size.
- R10: Only one transaction is in flight. `host_req_ready` is 0 from acceptance until the response is taken. A response held by `host_rsp_ready`=0 keeps `host_rsp_valid` and its data stable.
- R11: An access to any offset other than the two registers returns 0 and sends no downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| host_req_valid | input | 1 | host request valid |
| host_req_ready | output | 1 | bridge can take a request |
| host_req_write | input | 1 | 1 write, 0 read |
| host_req_off | input | ADDR_W | byte offset in register space |
| host_req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_req_wdata | input | 32 | write data, right-aligned |
| host_rsp_valid | output | 1 | response valid |
| host_rsp_ready | input | 1 | host takes response |
| host_rsp_rdata | output | 32 | read data, right-aligned |
| host_rsp_nf | output | 1 | device-not-found status |
| link_ready | input | 1 | secondary link is up |
| ds_req_valid | output | 1 | downstream request valid |
| ds_req_ready | input | 1 | downstream takes request |
| ds_req_write | output | 1 | configuration write |
| ds_req_addr | output | 32 | packed configuration address |
| ds_req_wdata | output | 32 | lane-steered write data |
| ds_req_be | output | 4 | byte enables |
| ds_rsp_valid | input | 1 | completion pulse |
| ds_rsp_err | input | 1 | completion error |
| ds_rsp_rdata | input | 32 | completion dword |

## Verification
The bench builds the bridge with its default parameters. ADDR_W=8 puts both registers and an unused offset (0x40) within one byte of offset. SEC_BUS=1 lets a bus-1 address exercise the link gate, while bus 0 takes the normal path. The downstream model toggles `ds_req_ready` every cycle and answers after several cycles, so request hold under back-pressure and the wait state are both exercised. A device-31 address draws an error completion.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned CFG_DW    = 32;
  localparam int unsigned CFG_LANES = CFG_DW / 8;
  localparam int unsigned LANE_W    = $clog2(CFG_LANES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } cfgb_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= {wdata[CFG_DW-1:2], 2'b00};
  end
endmodule

// File: rtl/cfgb_lanes.sv
module cfgb_lanes
  import cfgb_pkg::*;
(
  input  logic [LANE_W-1:0]    wr_lane,
  input  logic [1:0]           wr_size,
  input  logic [CFG_DW-1:0]    wr_data,
  output logic [CFG_LANES-1:0] wr_be,
  output logic [CFG_DW-1:0]    wr_shifted,
  input  logic [LANE_W-1:0]    rd_lane,
  input  logic [1:0]           rd_size,
  input  logic [CFG_DW-1:0]    rd_raw,
  output logic [CFG_DW-1:0]    rd_data
);
  logic [CFG_DW-1:0] rd_down;

  always_comb begin
    case (wr_size)
      SZ_BYTE: begin
        wr_be      = CFG_LANES'(1) << wr_lane;
        wr_shifted = {{(CFG_DW-8){1'b0}}, wr_data[7:0]} << {wr_lane, 3'b000};
      end
      SZ_HALF: begin
        wr_be      = CFG_LANES'(3) << wr_lane;
        wr_shifted = {{(CFG_DW-16){1'b0}}, wr_data[15:0]} << {wr_lane, 3'b000};
      end
      default: begin
        wr_be      = '1;
        wr_shifted = wr_data;
      end
    endcase
  end

  always_comb begin
    rd_down = rd_raw >> {rd_lane, 3'b000};
    case (rd_size)
      SZ_BYTE: rd_data = {{(CFG_DW-8){1'b0}}, rd_down[7:0]};
      SZ_HALF: rd_data = {{(CFG_DW-16){1'b0}}, rd_down[15:0]};
      default: rd_data = rd_raw;
    endcase
  end
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'('h20),
  parameter logic [ADDR_W-1:0] OFF_DATA = ADDR_W'('h24),
  parameter logic [7:0]        SEC_BUS  = 8'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req_valid,
  output logic                 host_req_ready,
  input  logic                 host_req_write,
  input  logic [ADDR_W-1:0]    host_req_off,
  input  logic [1:0]           host_req_size,
  input  logic [CFG_DW-1:0]    host_req_wdata,
  output logic                 host_rsp_valid,
  input  logic                 host_rsp_ready,
  output logic [CFG_DW-1:0]    host_rsp_rdata,
  output logic                 host_rsp_nf,
  input  logic                 link_ready,
  input  logic [CFG_DW-1:0]    cfg_addr,
  output logic                 addr_we,
  input  logic [CFG_LANES-1:0] lane_be,
  input  logic [CFG_DW-1:0]    lane_wdata,
  output logic [LANE_W-1:0]    rd_lane,
  output logic [1:0]           rd_size,
  input  logic [CFG_DW-1:0]    rd_steered,
  output logic                 ds_req_valid,
  input  logic                 ds_req_ready,
  output logic                 ds_req_write,
  output logic [CFG_DW-1:0]    ds_req_addr,
  output logic [CFG_DW-1:0]    ds_req_wdata,
  output logic [CFG_LANES-1:0] ds_req_be,
  input  logic                 ds_rsp_valid,
  input  logic                 ds_rsp_err
);
  cfgb_state_e state;
  logic accept, hit_addr, hit_data, blocked;

  assign host_req_ready = (state == ST_IDLE);
  assign host_rsp_valid = (state == ST_RESP);
  assign ds_req_valid   = (state == ST_ISSUE);
  assign accept   = host_req_valid && host_req_ready;
  assign hit_addr = host_req_off[ADDR_W-1:2] == OFF_ADDR[ADDR_W-1:2];
  assign hit_data = host_req_off[ADDR_W-1:2] == OFF_DATA[ADDR_W-1:2];
  assign blocked  = !link_ready && (cfg_addr[23:16] == SEC_BUS);
  assign addr_we  = accept && hit_addr && host_req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      host_rsp_rdata <= '0;
      host_rsp_nf    <= 1'b0;
      ds_req_write   <= 1'b0;
      ds_req_addr    <= '0;
      ds_req_wdata   <= '0;
      ds_req_be      <= '0;
      rd_lane        <= '0;
      rd_size        <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          host_rsp_nf <= 1'b0;
          if (hit_addr) begin
            host_rsp_rdata <= host_req_write ? '0 : cfg_addr;
            state          <= ST_RESP;
          end else if (hit_data && !cfg_addr[CFG_DW-1]) begin
            host_rsp_rdata <= host_req_write ? '0 : '1;
            state          <= ST_RESP;
          end else if (hit_data && blocked) begin
            host_rsp_rdata <= host_req_write ? '0 : '1;
            host_rsp_nf    <= 1'b1;
            state          <= ST_RESP;
          end else if (hit_data) begin
            ds_req_write <= host_req_write;
            ds_req_addr  <= {cfg_addr[CFG_DW-1:2], 2'b00};
            ds_req_wdata <= lane_wdata;
            ds_req_be    <= host_req_write ? lane_be : '1;
            rd_lane      <= host_req_off[LANE_W-1:0];
            rd_size      <= host_req_size;
            state        <= ST_ISSUE;
          end else begin
            host_rsp_rdata <= '0;
            state          <= ST_RESP;
          end
        end
        ST_ISSUE: if (ds_req_ready) state <= ST_WAIT;
        ST_WAIT: if (ds_rsp_valid) begin
          host_rsp_rdata <= ds_req_write ? '0 : (ds_rsp_err ? '1 : rd_steered);
          state          <= ST_RESP;
        end
        default: if (host_rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_rdata));
  // R10
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req_valid || host_rsp_valid) |-> !host_req_ready);
  // R4
  ds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_valid && !ds_req_ready |=> ds_req_valid && $stable(ds_req_addr) && $stable(ds_req_be));
  // R8
  link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_req_valid) |-> $past(link_ready) || (ds_req_addr[23:16] != SEC_BUS));
  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_valid |-> ds_req_addr[CFG_DW-1] && (ds_req_addr[1:0] == 2'b00));
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'('h20),
  parameter logic [ADDR_W-1:0] OFF_DATA = ADDR_W'('h24),
  parameter logic [7:0]        SEC_BUS  = 8'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [ADDR_W-1:0] host_req_off,
  input  logic [1:0]        host_req_size,
  input  logic [31:0]       host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [31:0]       host_rsp_rdata,
  output logic              host_rsp_nf,
  input  logic              link_ready,
  output logic              ds_req_valid,
  input  logic              ds_req_ready,
  output logic              ds_req_write,
  output logic [31:0]       ds_req_addr,
  output logic [31:0]       ds_req_wdata,
  output logic [3:0]        ds_req_be,
  input  logic              ds_rsp_valid,
  input  logic              ds_rsp_err,
  input  logic [31:0]       ds_rsp_rdata
);
  logic [CFG_DW-1:0]    cfg_addr, lane_wdata, rd_steered;
  logic [CFG_LANES-1:0] lane_be;
  logic [LANE_W-1:0]    rd_lane;
  logic [1:0]           rd_size;
  logic                 addr_we;

  cfgb_addr_reg u_areg (
    .clk(clk), .rst_n(rst_n), .we(addr_we), .wdata(host_req_wdata), .q(cfg_addr)
  );

  cfgb_lanes u_lanes (
    .wr_lane(host_req_off[LANE_W-1:0]), .wr_size(host_req_size), .wr_data(host_req_wdata),
    .wr_be(lane_be), .wr_shifted(lane_wdata),
    .rd_lane(rd_lane), .rd_size(rd_size), .rd_raw(ds_rsp_rdata), .rd_data(rd_steered)
  );

  cfgb_ctrl #(
    .ADDR_W(ADDR_W), .OFF_ADDR(OFF_ADDR), .OFF_DATA(OFF_DATA), .SEC_BUS(SEC_BUS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_off(host_req_off),
    .host_req_size(host_req_size), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata), .host_rsp_nf(host_rsp_nf),
    .link_ready(link_ready), .cfg_addr(cfg_addr), .addr_we(addr_we),
    .lane_be(lane_be), .lane_wdata(lane_wdata),
    .rd_lane(rd_lane), .rd_size(rd_size), .rd_steered(rd_steered),
    .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready),
    .ds_req_write(ds_req_write), .ds_req_addr(ds_req_addr),
    .ds_req_wdata(ds_req_wdata), .ds_req_be(ds_req_be),
    .ds_rsp_valid(ds_rsp_valid), .ds_rsp_err(ds_rsp_err)
  );
endmodule

// File: tb/cfg_bridge_test.sv
`timescale 1ns/1ps
module cfg_bridge_test;
  logic clk = 0, rst_n = 0;
  logic host_req_valid = 0, host_req_ready, host_req_write = 0;
  logic [7:0] host_req_off = 0;
  logic [1:0] host_req_size = 0;
  logic [31:0] host_req_wdata = 0;
  logic host_rsp_valid, host_rsp_ready = 0, host_rsp_nf;
  logic [31:0] host_rsp_rdata;
  logic link_ready = 1;
  logic ds_req_valid, ds_req_ready, ds_req_write;
  logic [31:0] ds_req_addr, ds_req_wdata;
  logic [3:0] ds_req_be;
  logic ds_rsp_valid, ds_rsp_err;
  logic [31:0] ds_rsp_rdata;

  int checks = 0, fails = 0;
  int req_cnt;
  logic [31:0] last_addr;
  logic last_write;
  logic [31:0] mem [16];
  logic pend;
  int lat;

  always #10 clk = ~clk;

  cfg_bridge uut (.*);

  // downstream target model: ready toggles, answers a few cycles later
  always @(posedge clk) begin
    ds_rsp_valid <= 1'b0;
    if (!rst_n) begin
      ds_req_ready <= 1'b0; pend <= 1'b0; req_cnt <= 0; lat <= 0;
      ds_rsp_err <= 1'b0; ds_rsp_rdata <= '0; last_addr <= '0; last_write <= 1'b0;
    end else begin
      ds_req_ready <= ~ds_req_ready;
      if (ds_req_valid && ds_req_ready) begin
        req_cnt <= req_cnt + 1; last_addr <= ds_req_addr; last_write <= ds_req_write;
        ds_rsp_err <= (ds_req_addr[15:11] == 5'd31);
        ds_rsp_rdata <= mem[ds_req_addr[5:2]];
        if (ds_req_write)
          for (int b = 0; b < 4; b++)
            if (ds_req_be[b]) mem[ds_req_addr[5:2]][8*b +: 8] <= ds_req_wdata[8*b +: 8];
        pend <= 1'b1; lat <= 3;
      end else if (pend) begin
        if (lat == 0) begin ds_rsp_valid <= 1'b1; pend <= 1'b0; end
        else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input int hold,
                        output logic [31:0] rd, output logic nf);
    @(negedge clk);
    host_req_valid = 1; host_req_write = wr; host_req_off = off;
    host_req_size = sz; host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 0;
    while (!host_rsp_valid) @(negedge clk);
    rd = host_rsp_rdata; nf = host_rsp_nf;
    for (int i = 0; i < hold; i++) begin
      chk("R10 held valid", {31'b0, host_rsp_valid}, 32'd1);
      chk("R10 held data", host_rsp_rdata, rd);
      chk("R10 no new request", {31'b0, host_req_ready}, 32'd0);
      @(negedge clk);
    end
    host_rsp_ready = 1;
    @(negedge clk);
    host_rsp_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic nf;
    chk("R1 req_ready", {31'b0, host_req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, host_rsp_valid}, 32'd0);
    chk("R1 ds_valid", {31'b0, ds_req_valid}, 32'd0);
    access(0, 8'h20, 2'd2, 0, 0, rd, nf);
    chk("R1 addr reg", rd, 32'h0);
  endtask

  task automatic t_addr_reg;
    logic [31:0] rd; logic nf;
    access(1, 8'h20, 2'd2, 32'h8001_0A07, 0, rd, nf);
    access(0, 8'h20, 2'd2, 0, 0, rd, nf);
    chk("R2 readback", rd, 32'h8001_0A04);
  endtask

  task automatic t_word_rw;
    logic [31:0] rd; logic nf; int c0;
    access(1, 8'h20, 2'd2, 32'h8000_0809, 0, rd, nf);
    c0 = req_cnt;
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R4 word read data", rd, mem[2]);
    chk("R4 one read", req_cnt - c0, 1);
    chk("R4 read kind", {31'b0, last_write}, 0);
    chk("R3 packed addr", last_addr, 32'h8000_0808);
    access(1, 8'h27, 2'd2, 32'hCAFE_F00D, 0, rd, nf);
    chk("R4 one write", req_cnt - c0, 2);
    chk("R4 write kind", {31'b0, last_write}, 1);
    chk("R5 word write ignores lane", mem[2], 32'hCAFE_F00D);
  endtask

  task automatic t_sub_read;
    logic [31:0] rd; logic nf;
    access(0, 8'h26, 2'd0, 0, 0, rd, nf);
    chk("R5 byte lane2", rd, 32'h0000_00FE);
    access(0, 8'h25, 2'd0, 0, 0, rd, nf);
    chk("R5 byte lane1", rd, 32'h0000_00F0);
    access(0, 8'h26, 2'd1, 0, 0, rd, nf);
    chk("R5 half lane2", rd, 32'h0000_CAFE);
    access(0, 8'h24, 2'd1, 0, 0, rd, nf);
    chk("R5 half lane0", rd, 32'h0000_F00D);
  endtask

  task automatic t_sub_write;
    logic [31:0] rd; logic nf;
    access(1, 8'h25, 2'd0, 32'hFFFF_FF5A, 0, rd, nf);
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R6 byte write merge", rd, 32'hCAFE_5A0D);
    access(1, 8'h26, 2'd1, 32'h1234_BEEF, 0, rd, nf);
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R6 half write merge", rd, 32'hBEEF_5A0D);
  endtask

  task automatic t_disabled;
    logic [31:0] rd; logic nf; int c0;
    access(1, 8'h20, 2'd2, 32'h0000_0808, 0, rd, nf);
    c0 = req_cnt;
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R7 disabled read", rd, 32'hFFFF_FFFF);
    access(1, 8'h24, 2'd2, 32'h0, 0, rd, nf);
    chk("R7 no downstream", req_cnt - c0, 0);
  endtask

  task automatic t_link;
    logic [31:0] rd; logic nf; int c0;
    access(1, 8'h20, 2'd2, 32'h8001_0004, 0, rd, nf);
    link_ready = 0;
    c0 = req_cnt;
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R8 blocked data", rd, 32'hFFFF_FFFF);
    chk("R8 not found", {31'b0, nf}, 1);
    access(1, 8'h24, 2'd2, 32'h55, 0, rd, nf);
    chk("R8 write not found", {31'b0, nf}, 1);
    chk("R8 nothing sent", req_cnt - c0, 0);
    link_ready = 1;
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R8 link up found", {31'b0, nf}, 0);
    chk("R8 link up sent", req_cnt - c0, 1);
    chk("R8 link up data", rd, mem[1]);
  endtask

  task automatic t_err;
    logic [31:0] rd; logic nf;
    access(1, 8'h20, 2'd2, 32'h8000_F80C, 0, rd, nf);
    access(0, 8'h24, 2'd2, 0, 0, rd, nf);
    chk("R9 error word", rd, 32'hFFFF_FFFF);
    access(0, 8'h25, 2'd0, 0, 0, rd, nf);
    chk("R9 error byte", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold;
    logic [31:0] rd; logic nf;
    access(1, 8'h20, 2'd2, 32'h8000_0814, 0, rd, nf);
    access(0, 8'h24, 2'd2, 0, 5, rd, nf);
    chk("R10 held read data", rd, mem[5]);
  endtask

  task automatic t_other;
    logic [31:0] rd; logic nf; int c0;
    c0 = req_cnt;
    access(0, 8'h40, 2'd2, 0, 0, rd, nf);
    chk("R11 unused offset", rd, 32'h0);
    chk("R11 no downstream", req_cnt - c0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {4{8'(i)}} ^ 32'hC3A5_5A3C;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_addr_reg();
    t_word_rw();
    t_sub_read();
    t_sub_write();
    t_disabled();
    t_link();
    t_err();
    t_hold();
    t_other();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule